// File: doc/BRIEF.md
# Predicated Contiguous Vector Store Sequencer

This block turns one vector store request into a series of 64-bit memory write beats. A request carries a whole vector register value, a byte-granular predicate, a 64-bit base address, a signed 4-bit immediate and an element-width select (64-bit or 128-bit elements). The block walks the elements from index 0 upward. Each element occupies one 8-byte slot in memory. Every element whose predicate bit is set produces one write beat. The slot address advances by 8 after every element, whether or not that element produced a beat.

The start address is the base plus the immediate times the full in-memory footprint of the vector: element count times 8 bytes. The predicate does not affect this scaling. When the request flags its base as the stack pointer and the base is not 16-byte aligned, the block raises a one-cycle fault pulse and issues no beats. If no element is active, a configuration input decides whether the alignment check applies. A one-cycle done pulse ends every request that does not fault.

Top module: `pvs_store_seq`

## Requirements
- R1: A request is taken only on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the edge after acceptance until the terminating pulse. Requests presented while busy have no effect.
- R2: The first slot address is `base + sext(imm) * N * 8`, computed modulo 2^64. N is VLEN/64 when `req_wide`=0 and VLEN/128 when `req_wide`=1. The predicate does not change it.
- R3: Beats leave in ascending element order. The beat for element e carries address `start + 8*e`, even when earlier elements were inactive.
- R4: Element e is active when `req_pred[8*e]` is set (`req_wide`=0) or when `req_pred[16*e]` is set (`req_wide`=1). All other predicate bits are ignored.
- R5: The beat data for element e is `req_vec[64*e +: 64]` when `req_wide`=0 and `req_vec[128*e +: 64]` when `req_wide`=1. `wr_strb` is 8'hFF on every beat.
- R6: An inactive element produces no beat.
- R7: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold their values.
- R8: If `req_base_is_sp`=1, `req_base[3:0]`≠0 and at least one element is active, the request ends with `fault` high for one cycle. No beats are issued and no done pulse follows.
- R9: If `req_base_is_sp`=1, `req_base[3:0]`≠0 and no element is active, the request faults when `cfg_chk_empty`=1. When `cfg_chk_empty`=0, it completes with done and no beats.
- R10: A misaligned base with `req_base_is_sp`=0 never faults.
- R11: `done` and `fault` are single-cycle pulses and never occur together. `fault` is visible in the cycle right after the accepting edge. With `wr_ready` held high, `done` is visible N+1 cycles after the accepting edge.
- R12: After reset, `req_ready`=1 and `wr_valid`, `done` and `fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_vec | input | VLEN | Vector register value |
| req_pred | input | VLEN/8 | Predicate, one bit per vector byte |
| req_base | input | AW | Base address |
| req_base_is_sp | input | 1 | Base comes from the stack pointer |
| req_imm | input | 4 | Signed vector-footprint offset |
| req_wide | input | 1 | 1: 128-bit elements, 0: 64-bit elements |
| cfg_chk_empty | input | 1 | Apply stack alignment check when no element is active |
| wr_valid | output | 1 | Write beat valid |
| wr_ready | input | 1 | Memory accepts the beat |
| wr_addr | output | AW | Beat byte address |
| wr_data | output | 64 | Beat data |
| wr_strb | output | 8 | Byte strobes |
| done | output | 1 | Request completed pulse |
| fault | output | 1 | Stack alignment fault pulse |

## Verification
A fault is due in the first cycle after the accepting edge. With the write port always ready, done is due N+1 cycles after acceptance, and the bench counts cycles from the accepting edge to check this exactly. Under stalls, beat order and content are compared against a queue of expected beats, and only handshake cycles consume an entry. Inputs are driven and outputs sampled on the falling edge, so every compare reflects the state settled by the preceding rising edge.

// File: rtl/pvs_pkg.sv
`timescale 1ns/1ps
package pvs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } pvs_state_e;

  localparam int unsigned SLOT_BYTES = 8;
  localparam int unsigned BEAT_BITS  = 64;
endpackage

// File: rtl/pvs_start_addr.sv
`timescale 1ns/1ps
module pvs_start_addr #(
  parameter int unsigned VLEN = 512,
  parameter int unsigned AW   = 64
) (
  input  logic [AW-1:0] base,
  input  logic [3:0]    imm,
  input  logic          wide,
  output logic [AW-1:0] start
);
  localparam int unsigned SPAN_NARROW = (VLEN / 64) * pvs_pkg::SLOT_BYTES;
  localparam int unsigned SPAN_WIDE   = (VLEN / 128) * pvs_pkg::SLOT_BYTES;

  logic [AW-1:0] imm_x;
  logic [AW-1:0] span;
  logic [AW-1:0] offs;

  assign imm_x = {{(AW-4){imm[3]}}, imm};
  assign span  = wide ? AW'(SPAN_WIDE) : AW'(SPAN_NARROW);
  assign offs  = imm_x * span;
  assign start = base + offs;
endmodule

// File: rtl/pvs_lane_mask.sv
`timescale 1ns/1ps
module pvs_lane_mask #(
  parameter int unsigned VLEN = 512,
  parameter int unsigned NE   = VLEN / 64,
  parameter int unsigned PW   = VLEN / 8
) (
  input  logic [PW-1:0] pred,
  input  logic          wide,
  output logic [NE-1:0] act,
  output logic          any
);
  logic unused_pred_bits;
  assign unused_pred_bits = ^pred;

  for (genvar e = 0; e < NE; e++) begin : g_lane
    if (e < NE / 2) begin : g_both
      assign act[e] = wide ? pred[e*16] : pred[e*8];
    end else begin : g_narrow_only
      assign act[e] = wide ? 1'b0 : pred[e*8];
    end
  end

  assign any = |act;
endmodule

// File: rtl/pvs_lane_pick.sv
`timescale 1ns/1ps
module pvs_lane_pick #(
  parameter int unsigned VLEN = 512,
  parameter int unsigned NE   = VLEN / 64,
  parameter int unsigned IW   = $clog2(NE)
) (
  input  logic [VLEN-1:0] vec,
  input  logic [IW-1:0]   idx,
  input  logic            wide,
  output logic [63:0]     data
);
  logic [63:0] nar [NE];
  logic [63:0] wid [NE];

  for (genvar e = 0; e < NE; e++) begin : g_lane
    assign nar[e] = vec[e*64 +: 64];
    if (e < NE / 2) begin : g_wide
      assign wid[e] = vec[e*128 +: 64];
    end else begin : g_pad
      assign wid[e] = '0;
    end
  end

  assign data = wide ? wid[idx] : nar[idx];
endmodule

// File: rtl/pvs_store_seq.sv
`timescale 1ns/1ps
module pvs_store_seq #(
  parameter int unsigned VLEN = 512,
  parameter int unsigned AW   = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VLEN-1:0]   req_vec,
  input  logic [VLEN/8-1:0] req_pred,
  input  logic [AW-1:0]     req_base,
  input  logic              req_base_is_sp,
  input  logic [3:0]        req_imm,
  input  logic              req_wide,
  input  logic              cfg_chk_empty,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [AW-1:0]     wr_addr,
  output logic [63:0]       wr_data,
  output logic [7:0]        wr_strb,
  output logic              done,
  output logic              fault
);
  import pvs_pkg::*;

  localparam int unsigned NE = VLEN / 64;
  localparam int unsigned IW = $clog2(NE);
  localparam int unsigned PW = VLEN / 8;
  localparam logic [IW-1:0] LAST_NARROW = IW'(NE - 1);
  localparam logic [IW-1:0] LAST_WIDE   = IW'(NE / 2 - 1);

  pvs_state_e      state_q;
  logic [IW-1:0]   idx_q;
  logic [IW-1:0]   last_q;
  logic [NE-1:0]   act_q;
  logic [VLEN-1:0] vec_q;
  logic            wide_q;
  logic [AW-1:0]   addr_q;

  logic [AW-1:0]   start_addr;
  logic [NE-1:0]   in_act;
  logic            in_any;
  logic [63:0]     pick_data;
  logic            take;
  logic            sp_fault;
  logic            slot_free;

  pvs_start_addr #(.VLEN(VLEN), .AW(AW)) u_start (
    .base  (req_base),
    .imm   (req_imm),
    .wide  (req_wide),
    .start (start_addr)
  );

  pvs_lane_mask #(.VLEN(VLEN), .NE(NE), .PW(PW)) u_mask (
    .pred (req_pred),
    .wide (req_wide),
    .act  (in_act),
    .any  (in_any)
  );

  pvs_lane_pick #(.VLEN(VLEN), .NE(NE), .IW(IW)) u_pick (
    .vec  (vec_q),
    .idx  (idx_q),
    .wide (wide_q),
    .data (pick_data)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign take      = req_valid && req_ready;
  assign sp_fault  = req_base_is_sp && (req_base[3:0] != 4'd0) && (in_any || cfg_chk_empty);
  assign slot_free = !wr_valid || wr_ready;
  assign wr_strb   = 8'hFF;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      last_q   <= '0;
      act_q    <= '0;
      vec_q    <= '0;
      wide_q   <= 1'b0;
      addr_q   <= '0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      done     <= 1'b0;
      fault    <= 1'b0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      if (wr_valid && wr_ready) wr_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (take) begin
            if (sp_fault) begin
              fault <= 1'b1;
            end else begin
              state_q <= ST_RUN;
              idx_q   <= '0;
              addr_q  <= start_addr;
              act_q   <= in_act;
              vec_q   <= req_vec;
              wide_q  <= req_wide;
              last_q  <= req_wide ? LAST_WIDE : LAST_NARROW;
            end
          end
        end
        ST_RUN: begin
          if (slot_free) begin
            if (act_q[idx_q]) begin
              wr_valid <= 1'b1;
              wr_addr  <= addr_q;
              wr_data  <= pick_data;
            end
            addr_q <= addr_q + AW'(SLOT_BYTES);
            idx_q  <= idx_q + 1'b1;
            if (idx_q == last_q) state_q <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (slot_free) begin
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R7: a stalled beat keeps its contents
  p_hold_beat_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R8: a faulting request never drives a beat
  p_fault_no_beat_r8: assert property (@(posedge clk) disable iff (rst)
    fault |-> !wr_valid);

  // R11: the two terminating pulses are exclusive
  p_one_end_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, fault}));

  // R11: done lasts a single cycle
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R1: an idle block has no beat outstanding
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !wr_valid);
endmodule

// File: tb/sim_pvs_store_seq.sv
`timescale 1ns/1ps
module sim_pvs_store_seq;
  localparam int VLEN = 512;
  localparam int PW   = VLEN / 8;
  localparam int AW   = 64;

  logic            clk = 1'b0;
  logic            rst;
  logic            req_valid;
  logic            req_ready;
  logic [VLEN-1:0] req_vec;
  logic [PW-1:0]   req_pred;
  logic [AW-1:0]   req_base;
  logic            req_base_is_sp;
  logic [3:0]      req_imm;
  logic            req_wide;
  logic            cfg_chk_empty;
  logic            wr_valid;
  logic            wr_ready;
  logic [AW-1:0]   wr_addr;
  logic [63:0]     wr_data;
  logic [7:0]      wr_strb;
  logic            done;
  logic            fault;

  always #4 clk = ~clk;

  pvs_store_seq #(.VLEN(VLEN), .AW(AW)) u0 (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vec(req_vec), .req_pred(req_pred), .req_base(req_base),
    .req_base_is_sp(req_base_is_sp), .req_imm(req_imm), .req_wide(req_wide),
    .cfg_chk_empty(cfg_chk_empty),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_strb(wr_strb), .done(done), .fault(fault)
  );

  int tests = 0;
  int fails = 0;
  logic [63:0] q_addr [$];
  logic [63:0] q_data [$];
  bit exp_fault;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [VLEN-1:0] rnd_vec();
    logic [VLEN-1:0] v;
    for (int i = 0; i < VLEN / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic run_req(input logic [VLEN-1:0] vec, input logic [PW-1:0] pred,
                         input logic [63:0] base, input bit sp, input logic [3:0] imm,
                         input bit wide, input bit chk_empty, input int rmode,
                         input bit junk, input string tag);
    int n;
    longint off;
    logic [63:0] a;
    bit anyact;
    bit fin;
    int cyc;
    n = wide ? VLEN / 128 : VLEN / 64;
    anyact = 1'b0;
    q_addr.delete();
    q_data.delete();
    off = longint'($signed(imm)) * n * 8;
    a = base + 64'(off);
    for (int e = 0; e < n; e++) begin
      if (pred[wide ? e*16 : e*8]) begin
        q_addr.push_back(a);
        q_data.push_back(vec[e*(wide ? 128 : 64) +: 64]);
        anyact = 1'b1;
      end
      a = a + 64'd8;
    end
    exp_fault = sp && (base[3:0] != 4'd0) && (anyact || chk_empty);
    if (exp_fault) begin
      q_addr.delete();
      q_data.delete();
    end

    @(negedge clk);
    req_vec = vec; req_pred = pred; req_base = base; req_base_is_sp = sp;
    req_imm = imm; req_wide = wide; cfg_chk_empty = chk_empty;
    req_valid = 1'b1;
    wr_ready = 1'b1;
    chk(req_ready == 1'b1, "R1", "ready before request", 64'(req_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    fin = 1'b0;
    while (!fin && cyc < 400) begin
      wr_ready = (rmode == 0) ? 1'b1 : ((cyc % 3) != 1);
      if (cyc == 0 && !exp_fault)
        chk(req_ready == 1'b0, "R1", "busy after accept", 64'(req_ready), 64'd0);
      if (wr_valid) begin
        if (q_addr.size() == 0) begin
          chk(1'b0, "R6", "unexpected beat", wr_addr, 64'd0);
        end else if (wr_ready) begin
          chk(wr_addr == q_addr[0], "R3", "beat address", wr_addr, q_addr[0]);
          chk(wr_data == q_data[0], "R5", "beat data", wr_data, q_data[0]);
          chk(wr_strb == 8'hFF, "R5", "strobe", 64'(wr_strb), 64'hFF);
          void'(q_addr.pop_front());
          void'(q_data.pop_front());
        end
      end
      if (done || fault) begin
        fin = 1'b1;
        chk(fault == exp_fault, tag, "fault outcome", 64'(fault), 64'(exp_fault));
        chk(q_addr.size() == 0, tag, "missing beats", 64'(q_addr.size()), 64'd0);
        if (fault)
          chk(cyc == 0, "R11", "fault timing", 64'(cyc), 64'd0);
        else if (rmode == 0)
          chk(cyc == n + 1, "R11", "done timing", 64'(cyc), 64'(n + 1));
        req_valid = 1'b0;
      end else begin
        if (junk) begin
          req_valid = !req_ready;
          req_vec = rnd_vec();
          req_pred = '1;
          req_base = 64'hDEAD_0000;
          req_imm = 4'd3;
        end
        @(posedge clk);
        @(negedge clk);
        cyc++;
      end
    end
    if (!fin) chk(1'b0, tag, "request timeout", 64'(cyc), 64'd0);
    req_valid = 1'b0;
    wr_ready = 1'b1;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL R1 watchdog expired: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1;
    req_valid = 1'b0; req_vec = '0; req_pred = '0; req_base = '0;
    req_base_is_sp = 1'b0; req_imm = '0; req_wide = 1'b0;
    cfg_chk_empty = 1'b0; wr_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R12", "reset ready", 64'(req_ready), 64'd1);
    chk(wr_valid == 1'b0, "R12", "reset wr_valid", 64'(wr_valid), 64'd0);
    chk(done == 1'b0, "R12", "reset done", 64'(done), 64'd0);
    chk(fault == 1'b0, "R12", "reset fault", 64'(fault), 64'd0);

    run_req(rnd_vec(), '1, 64'h1000, 1'b0, 4'd0, 1'b0, 1'b0, 0, 1'b0, "R2");
    run_req(rnd_vec(), 64'h0100_0001_0001_0101, 64'h8000, 1'b0, 4'h8, 1'b0, 1'b0, 1, 1'b0, "R6");
    run_req(rnd_vec(), 64'h0101_0100_0100_0101, 64'h2000, 1'b0, 4'd7, 1'b1, 1'b0, 0, 1'b0, "R4");
    run_req(rnd_vec(), 64'hFEFE_FEFE_FEFE_FEFE, 64'h3000, 1'b0, 4'd2, 1'b0, 1'b0, 0, 1'b0, "R4");
    run_req(rnd_vec(), '1, 64'h2004, 1'b1, 4'd0, 1'b0, 1'b0, 0, 1'b0, "R8");
    run_req(rnd_vec(), '0, 64'h2008, 1'b1, 4'd0, 1'b0, 1'b1, 0, 1'b0, "R9");
    run_req(rnd_vec(), '0, 64'h2008, 1'b1, 4'd0, 1'b0, 1'b0, 0, 1'b0, "R9");
    run_req(rnd_vec(), '1, 64'h3010, 1'b1, 4'd1, 1'b0, 1'b0, 1, 1'b0, "R8");
    run_req(rnd_vec(), '1, 64'h4003, 1'b0, 4'd1, 1'b0, 1'b0, 0, 1'b0, "R10");
    run_req(rnd_vec(), '1, 64'hFFFF_FFFF_FFFF_FFF0, 1'b0, 4'd7, 1'b0, 1'b0, 0, 1'b0, "R2");
    run_req(rnd_vec(), 64'h0180_0101_8001_0101, 64'h5000, 1'b0, 4'd1, 1'b0, 1'b0, 0, 1'b1, "R1");
    run_req(rnd_vec(), '1, 64'h0, 1'b0, 4'hF, 1'b1, 1'b0, 1, 1'b0, "R7");
    run_req(rnd_vec(), '1, 64'h6008, 1'b1, 4'd0, 1'b1, 1'b0, 0, 1'b0, "R8");

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule